// File: doc/BRIEF.md
# Configurable Output Macrocell

This block is the output stage of a sum-of-products logic array. The array delivers one sum term and one output-enable term for each cell, plus two terms that all cells share: one that clears every register at once and one that sets every register at the next clock edge. Two configuration bits per cell set the mode and the polarity. In registered mode the pin follows a D flip-flop. In combinational mode the pin follows the sum term directly. In either mode the polarity bit decides whether the pin is true or inverted.

The pad is modelled as three values: the level the cell would drive, the enable of that driver, and the level that an outside driver puts on the line. From these the cell resolves the level seen at the pad. The cell also returns one feedback bit to the array. In registered mode that bit is the inverted register output. In combinational mode it is the resolved pad level, so a disabled pin works as an input.

A test preload port forces any register state on a clock edge. An active-low power-up input clears all registers. The parameter `NCELL` sets how many cells share the common clear and set terms.

Top module: `omc_cell`

## Requirements
- R1: While `pwr_rst_n` is low, every register holds 0. A registered cell with `cfg_hi`=1 then drives 0, and one with `cfg_hi`=0 drives 1.
- R2: With `cfg_comb`=0 (registered), the register captures `sum_in` on each rising edge when no clear, preload or preset is active. The driven level is the register value when `cfg_hi`=1 and its inverse when `cfg_hi`=0.
- R3: With `cfg_comb`=1 (combinational), the driven level is `sum_in` when `cfg_hi`=1 and its inverse when `cfg_hi`=0. It changes in the same cycle as `sum_in`, without waiting for a clock edge.
- R4: A high `ar_term` clears all registers at once, without a clock edge, and holds them at 0 for as long as it stays high.
- R5: A high `sp_term` sets all registers to 1 at the next rising edge and not before.
- R6: Clear and set act on the stored value whatever the polarity. After a clear, a registered cell with `cfg_hi`=0 drives 1.
- R7: In registered mode `fb` is the inverse of the register value. It does not follow `pad_ext`, even when the driver is disabled.
- R8: In combinational mode `fb` equals the resolved pad level `pad_lvl`. When the driver is disabled this is `pad_ext`.
- R9: `pad_oe` follows `oe_term` in both modes. `pad_lvl` equals `pad_drv` when enabled and `pad_ext` when disabled.
- R10: When `ar_term` and `sp_term` are high together, the registers stay at 0.
- R11: With `pl_en` high, the rising edge loads `pl_data` in place of `sum_in`, and preload wins over `sp_term`. A high `ar_term` overrides preload.
- R12: `ar_term` and `sp_term` act on all cells in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| pwr_rst_n | input | 1 | Power-up clear, asynchronous, active low |
| cfg_comb | input | NCELL | Per-cell mode: 0 registered, 1 combinational |
| cfg_hi | input | NCELL | Per-cell polarity: 1 true, 0 inverted |
| sum_in | input | NCELL | Sum term from the array |
| oe_term | input | NCELL | Output-enable term for each cell |
| ar_term | input | 1 | Shared asynchronous clear term |
| sp_term | input | 1 | Shared synchronous set term |
| pl_en | input | 1 | Test preload enable |
| pl_data | input | NCELL | Preload state |
| pad_ext | input | NCELL | Level applied to the pad from outside |
| pad_drv | output | NCELL | Level the cell drives toward the pad |
| pad_oe | output | NCELL | Pad driver enable |
| pad_lvl | output | NCELL | Resolved pad level |
| fb | output | NCELL | Feedback to the array |

## Verification
The bench goes after the places where the two feedback sources and the two register controls can be confused. A registered cell whose feedback came from the pad would follow `pad_ext` while its driver is off. A set that acted on the pin instead of the stored value would show the wrong level on an inverted cell. A clear that waited for a clock edge is caught by a check placed between edges, just after `ar_term` rises. A set that acted at once is caught by a check made before the edge. The bench also asserts the terms in pairs (clear with set, preload with set, preload with clear), so that a wrong priority order leaves a visibly wrong register value.

// File: rtl/omc_pkg.sv
package omc_pkg;

  // Apply output polarity: hi=1 passes the source, hi=0 inverts it.
  function automatic logic pol_apply(input logic src, input logic hi);
    return hi ? src : ~src;
  endfunction

  // Feedback source: pad level in combinational mode, inverted register otherwise.
  function automatic logic fb_pick(input logic comb, input logic lvl, input logic q);
    return comb ? lvl : ~q;
  endfunction

  // Pad resolution: enabled driver wins, otherwise the external level.
  function automatic logic pad_resolve(input logic oe, input logic drv, input logic ext);
    return oe ? drv : ext;
  endfunction

endpackage

// File: rtl/omc_ff.sv
module omc_ff #(
  parameter int NCELL = 2
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             sp,
  input  logic             pl_en,
  input  logic [NCELL-1:0] pl_data,
  input  logic [NCELL-1:0] d,
  output logic [NCELL-1:0] q
);
  localparam logic [NCELL-1:0] ALL_ONE = {NCELL{1'b1}};

  // Clear is asynchronous; preload, then set, then data on the edge.
  always_ff @(posedge clk or posedge clr) begin
    if (clr)        q <= '0;
    else if (pl_en) q <= pl_data;
    else if (sp)    q <= ALL_ONE;
    else            q <= d;
  end
endmodule

// File: rtl/omc_drive.sv
module omc_drive
  import omc_pkg::*;
#(
  parameter int NCELL = 2
) (
  input  logic [NCELL-1:0] q,
  input  logic [NCELL-1:0] sum_in,
  input  logic [NCELL-1:0] cfg_comb,
  input  logic [NCELL-1:0] cfg_hi,
  output logic [NCELL-1:0] drv
);
  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic src;
    assign src    = cfg_comb[i] ? sum_in[i] : q[i];
    assign drv[i] = pol_apply(src, cfg_hi[i]);
  end
endmodule

// File: rtl/omc_pad.sv
module omc_pad
  import omc_pkg::*;
#(
  parameter int NCELL = 2
) (
  input  logic [NCELL-1:0] drv,
  input  logic [NCELL-1:0] oe,
  input  logic [NCELL-1:0] ext,
  input  logic [NCELL-1:0] q,
  input  logic [NCELL-1:0] cfg_comb,
  output logic [NCELL-1:0] lvl,
  output logic [NCELL-1:0] fb
);
  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    assign lvl[i] = pad_resolve(oe[i], drv[i], ext[i]);
    assign fb[i]  = fb_pick(cfg_comb[i], lvl[i], q[i]);
  end
endmodule

// File: rtl/omc_cell.sv
module omc_cell #(
  parameter int NCELL = 2
) (
  input  logic             clk,
  input  logic             pwr_rst_n,
  input  logic [NCELL-1:0] cfg_comb,
  input  logic [NCELL-1:0] cfg_hi,
  input  logic [NCELL-1:0] sum_in,
  input  logic [NCELL-1:0] oe_term,
  input  logic             ar_term,
  input  logic             sp_term,
  input  logic             pl_en,
  input  logic [NCELL-1:0] pl_data,
  input  logic [NCELL-1:0] pad_ext,
  output logic [NCELL-1:0] pad_drv,
  output logic [NCELL-1:0] pad_oe,
  output logic [NCELL-1:0] pad_lvl,
  output logic [NCELL-1:0] fb
);
  // Named internal events, visible to the bound checker.
  logic             clr_evt;
  logic [NCELL-1:0] q_r;
  logic [NCELL-1:0] drv_w;
  logic [NCELL-1:0] lvl_w;

  assign clr_evt = ar_term | ~pwr_rst_n;

  omc_ff #(.NCELL(NCELL)) u_ff (
    .clk     (clk),
    .clr     (clr_evt),
    .sp      (sp_term),
    .pl_en   (pl_en),
    .pl_data (pl_data),
    .d       (sum_in),
    .q       (q_r)
  );

  omc_drive #(.NCELL(NCELL)) u_drive (
    .q        (q_r),
    .sum_in   (sum_in),
    .cfg_comb (cfg_comb),
    .cfg_hi   (cfg_hi),
    .drv      (drv_w)
  );

  omc_pad #(.NCELL(NCELL)) u_pad (
    .drv      (drv_w),
    .oe       (oe_term),
    .ext      (pad_ext),
    .q        (q_r),
    .cfg_comb (cfg_comb),
    .lvl      (lvl_w),
    .fb       (fb)
  );

  assign pad_drv = drv_w;
  assign pad_oe  = oe_term;
  assign pad_lvl = lvl_w;
endmodule

// File: rtl/omc_cell_chk.sv
module omc_cell_chk #(
  parameter int NCELL = 2
) (
  input logic             clk,
  input logic             pwr_rst_n,
  input logic             clr_evt,
  input logic [NCELL-1:0] q_r,
  input logic [NCELL-1:0] cfg_comb,
  input logic [NCELL-1:0] sum_in,
  input logic [NCELL-1:0] oe_term,
  input logic             sp_term,
  input logic             pl_en,
  input logic [NCELL-1:0] pl_data,
  input logic [NCELL-1:0] pad_ext,
  input logic [NCELL-1:0] pad_drv,
  input logic [NCELL-1:0] pad_lvl,
  input logic [NCELL-1:0] fb
);
  localparam logic [NCELL-1:0] ALL_ONE = {NCELL{1'b1}};

  AST_CLR_HOLDS: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    clr_evt |-> q_r == '0); // R4

  AST_SET_NEXT: assert property (@(posedge clk) disable iff (clr_evt)
    (sp_term && !pl_en) |=> q_r == ALL_ONE); // R5

  AST_PRELOAD: assert property (@(posedge clk) disable iff (clr_evt)
    pl_en |=> q_r == $past(pl_data)); // R11

  AST_CAPTURE: assert property (@(posedge clk) disable iff (clr_evt)
    (!pl_en && !sp_term) |=> q_r == $past(sum_in)); // R2

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    AST_REG_FB: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      !cfg_comb[i] |-> fb[i] == ~q_r[i]); // R7

    AST_COMB_FB: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      cfg_comb[i] |-> fb[i] == pad_lvl[i]); // R8

    AST_OE_OFF: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      !oe_term[i] |-> pad_lvl[i] == pad_ext[i]); // R9

    AST_OE_ON: assert property (@(posedge clk) disable iff (!pwr_rst_n)
      oe_term[i] |-> pad_lvl[i] == pad_drv[i]); // R9
  end
endmodule

bind omc_cell omc_cell_chk #(.NCELL(NCELL)) u_chk (
  .clk       (clk),
  .pwr_rst_n (pwr_rst_n),
  .clr_evt   (clr_evt),
  .q_r       (q_r),
  .cfg_comb  (cfg_comb),
  .sum_in    (sum_in),
  .oe_term   (oe_term),
  .sp_term   (sp_term),
  .pl_en     (pl_en),
  .pl_data   (pl_data),
  .pad_ext   (pad_ext),
  .pad_drv   (pad_drv),
  .pad_lvl   (pad_lvl),
  .fb        (fb)
);

// File: tb/omc_cell_tb.sv
`timescale 1ns/1ps
module omc_cell_tb;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         pwr_rst_n;
  logic [N-1:0] cfg_comb, cfg_hi, sum_in, oe_term, pl_data, pad_ext;
  logic         ar_term, sp_term, pl_en;
  logic [N-1:0] pad_drv, pad_oe, pad_lvl, fb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural model of the stored state.
  logic [N-1:0] mq = '0;

  always #2.5 clk = ~clk;

  omc_cell #(.NCELL(N)) u_dut (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .cfg_comb(cfg_comb), .cfg_hi(cfg_hi),
    .sum_in(sum_in), .oe_term(oe_term), .ar_term(ar_term), .sp_term(sp_term),
    .pl_en(pl_en), .pl_data(pl_data), .pad_ext(pad_ext),
    .pad_drv(pad_drv), .pad_oe(pad_oe), .pad_lvl(pad_lvl), .fb(fb)
  );

  always @(posedge clk) begin
    if (pwr_rst_n !== 1'b1 || ar_term) mq = '0;
    else if (pl_en)                    mq = pl_data;
    else if (sp_term)                  mq = '1;
    else                               mq = sum_in;
  end

  task automatic cmp(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check(string tag);
    logic [N-1:0] e_drv, e_lvl, e_fb;
    if (pwr_rst_n !== 1'b1 || ar_term) mq = '0;
    for (int i = 0; i < N; i++) begin
      logic s;
      s        = (cfg_comb[i] == 1'b1) ? sum_in[i] : mq[i];
      e_drv[i] = s ^ ~cfg_hi[i];
      e_lvl[i] = oe_term[i] ? e_drv[i] : pad_ext[i];
      e_fb[i]  = cfg_comb[i] ? e_lvl[i] : !mq[i];
    end
    cmp(tag, "pad_drv", pad_drv, e_drv);
    cmp(tag, "pad_oe",  pad_oe,  oe_term);
    cmp(tag, "pad_lvl", pad_lvl, e_lvl);
    cmp(tag, "fb",      fb,      e_fb);
  endtask

  // Inputs were just set at a falling edge: check between edges, then after the next edge.
  task automatic tick(string tag);
    #1 check(tag);
    @(negedge clk);
    check(tag);
  endtask

  task automatic quiet();
    ar_term = 0; sp_term = 0; pl_en = 0; pl_data = '0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pwr_rst_n = 0; cfg_comb = 2'b00; cfg_hi = 2'b01; sum_in = 2'b11;
    oe_term = 2'b11; pad_ext = 2'b00; quiet();
    @(negedge clk);
    // R1: cell0 true drives 0, cell1 inverted drives 1
    tick("R1 power-up clear");
    cmp("R1", "pad_drv explicit", pad_drv, 2'b10);
    tick("R1 power-up clear held");
    pwr_rst_n = 1;

    // R2/R7: registered capture, external level must not reach fb
    for (int k = 0; k < 8; k++) begin
      sum_in = k[1:0]; pad_ext = ~k[2:1]; oe_term = (k > 3) ? 2'b00 : 2'b11;
      tick("R2 R7 registered capture and feedback");
    end

    // R6/R12: clear on both cells with mixed polarity
    sum_in = 2'b11; oe_term = 2'b11; tick("R2 load ones");
    ar_term = 1; tick("R6 R12 clear both cells");
    cmp("R6", "inverted cell drives 1 after clear", pad_drv[1], 1'b1);
    ar_term = 0; tick("R6 release");

    // R4: clear mid-cycle, seen before the next rising edge
    sum_in = 2'b11; tick("R2 reload");
    #1 ar_term = 1;
    #0.5 check("R4 asynchronous clear");
    @(negedge clk); check("R4 clear held");
    ar_term = 0;

    // R5: set waits for the edge
    sum_in = 2'b00; tick("R2 zeros");
    sp_term = 1; tick("R5 R12 set at next edge");
    cmp("R5", "pad_drv after set", pad_drv, 2'b01);
    sp_term = 0; tick("R5 release");

    // R10: clear beats set
    ar_term = 1; sp_term = 1; tick("R10 clear over set");
    quiet(); sum_in = 2'b00; tick("R10 release");

    // R11: preload, preload over set, clear over preload
    pl_en = 1; pl_data = 2'b10; sum_in = 2'b01; tick("R11 preload");
    pl_data = 2'b01; sp_term = 1; tick("R11 preload over set");
    ar_term = 1; pl_data = 2'b11; tick("R11 clear over preload");
    quiet(); tick("R11 release");

    // R3/R8/R9: combinational mode, driver on and off
    cfg_comb = 2'b11;
    for (int k = 0; k < 16; k++) begin
      sum_in = k[1:0]; oe_term = k[3:2]; pad_ext = ~k[2:1];
      cfg_hi = (k[0]) ? 2'b10 : 2'b01;
      tick("R3 R8 R9 combinational");
    end

    // Mixed modes and polarities, pseudo-random stimulus
    for (int k = 0; k < 200; k++) begin
      cfg_comb = 2'($urandom); cfg_hi = 2'($urandom); sum_in = 2'($urandom);
      oe_term = 2'($urandom); pad_ext = 2'($urandom);
      ar_term = ($urandom % 16) == 0; sp_term = ($urandom % 8) == 0;
      pl_en = ($urandom % 8) == 0; pl_data = 2'($urandom);
      tick("R2 R3 R9 mixed");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule